// File: doc/BRIEF.md
# EEPROM Byte Address Counter

This block keeps the internal byte pointer of a 1 KiB two-wire serial EEPROM. The pointer is 10 bits wide. Its top two bits pick one of four 256-byte blocks, and its low eight bits pick a byte inside that block. A protocol front end drives it with strobes. One strobe carries the block bits of a received slave address together with the direction bit. Another strobe carries a received word-address byte. A third strobe, with a read/write mode, advances the pointer after each data byte moves across the bus.

The two kinds of advance wrap in different ways. A write advance changes only the low four bits, so a long burst of writes circles inside one 16-byte page. A read advance counts through the whole 10-bit space and goes from the last byte back to byte 0. Because the pointer always rests one past the last byte touched, a read that starts without a word address continues from that point. A write that carries only a word address (a dummy write) sets the start point for the next read.

Top module: `eaddr_ctr`

## Requirements
- R1: While `rst_n` is low, and after it is released, `addr` is 0 until a strobe arrives.
- R2: A `sel_ld` pulse with `sel_rw`=0 (write direction) copies `sel_blk` into `addr[9:8]` on the next clock. `addr[7:0]` is not changed.
- R3: A `word_ld` pulse copies `word_val` into `addr[7:0]` on the next clock. `addr[9:8]` is not changed.
- R4: An `adv` pulse with `adv_rd`=0 (write mode) sets `addr[3:0]` to (`addr[3:0]`+1) mod 16 and leaves `addr[9:4]` unchanged. After 0x1FF the next value is 0x1F0.
- R5: An `adv` pulse with `adv_rd`=1 (read mode) sets `addr` to (`addr`+1) mod 1024. The advance crosses 16-byte page and 256-byte block borders, and 0x3FF goes to 0x000.
- R6: A `sel_ld` pulse with `sel_rw`=1 (read direction) does not change `addr`, whatever the value of `sel_blk`. A current-address read therefore uses the stored pointer.
- R7: If a write-direction `sel_ld` or a `word_ld` falls in the same clock as `adv`, the advance is dropped. The loaded fields take their new values and any field that is not loaded keeps its value.
- R8: In a clock with no active strobe, `addr` keeps its value.
- R9: Take this sequence: a write-direction slave address with block b, then word byte w, then a read-direction slave address. Read advances after it then step the pointer through b*256+w+1, b*256+w+2, and so on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_ld | input | 1 | Slave-address received strobe |
| sel_rw | input | 1 | Direction bit of that slave address (1 = read) |
| sel_blk | input | 2 | Block-select bits of that slave address |
| word_ld | input | 1 | Word-address byte received strobe |
| word_val | input | 8 | Received word-address byte |
| adv | input | 1 | Advance after one data byte |
| adv_rd | input | 1 | Advance mode (1 = read, 0 = write) |
| addr | output | 10 | Current byte address |

## Verification
The assertions check four rules on every clock:
- a write advance keeps the upper six bits and steps the low nibble;
- a read advance adds one across the full width;
- loads beat advances;
- idle clocks and read-direction slave strobes leave the pointer unchanged.

Only the bench scenarios show the rules that depend on ordering:
- the exact wrap points 0x1FF to 0x1F0 and 0x3FF to 0x000;
- the pointer resting one past the last byte touched;
- a dummy-write sequence setting the start of the next sequential read.

// File: rtl/eaddr_pkg.sv
package eaddr_pkg;

  // Advance mode encoding: the value of the adv_rd pin
  typedef enum logic {
    ADV_WRITE = 1'b0,
    ADV_READ  = 1'b1
  } adv_mode_e;

  // Direction bit of a slave address
  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } sel_dir_e;

endpackage

// File: rtl/eaddr_next.sv
module eaddr_next
  import eaddr_pkg::*;
#(
  parameter int BLK_W  = 2,
  parameter int WORD_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic [BLK_W+WORD_W-1:0] cur,
  input  adv_mode_e               mode,
  output logic [BLK_W+WORD_W-1:0] nxt
);
  localparam int ADDR_W = BLK_W + WORD_W;

  // Read mode: carry runs through the whole pointer
  function automatic logic [ADDR_W-1:0] full_step(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  logic [ADDR_W-1:0] rd_nxt;
  logic [ADDR_W-1:0] wr_nxt;

  assign rd_nxt = full_step(cur);

  generate
    if (PAGE_W < ADDR_W) begin : g_page_wrap
      // Write mode: carry stops at the page boundary
      function automatic logic [ADDR_W-1:0] page_step(input logic [ADDR_W-1:0] a);
        logic [PAGE_W-1:0] low;
        low = a[PAGE_W-1:0] + PAGE_W'(1);
        return {a[ADDR_W-1:PAGE_W], low};
      endfunction
      assign wr_nxt = page_step(cur);
    end else begin : g_flat
      // The page covers the whole space, so both modes wrap alike
      assign wr_nxt = full_step(cur);
    end
  endgenerate

  always_comb begin
    nxt = (mode == ADV_READ) ? rd_nxt : wr_nxt;
  end

endmodule

// File: rtl/eaddr_load.sv
module eaddr_load
  import eaddr_pkg::*;
#(
  parameter int BLK_W  = 2,
  parameter int WORD_W = 8
) (
  input  logic [BLK_W+WORD_W-1:0] cur,
  input  logic                    sel_ld,
  input  sel_dir_e                sel_dir,
  input  logic [BLK_W-1:0]        sel_blk,
  input  logic                    word_ld,
  input  logic [WORD_W-1:0]       word_val,
  output logic [BLK_W+WORD_W-1:0] merged,
  output logic                    load_any
);
  localparam int ADDR_W = BLK_W + WORD_W;

  logic blk_take;
  logic [BLK_W-1:0]  blk_field;
  logic [WORD_W-1:0] word_field;

  // A read-direction slave address keeps the stored block bits
  assign blk_take = sel_ld && (sel_dir == DIR_WRITE);

  always_comb begin
    blk_field  = blk_take ? sel_blk  : cur[ADDR_W-1:WORD_W];
    word_field = word_ld  ? word_val : cur[WORD_W-1:0];
    merged     = {blk_field, word_field};
    load_any   = blk_take || word_ld;
  end

endmodule

// File: rtl/eaddr_ctr.sv
module eaddr_ctr
  import eaddr_pkg::*;
#(
  parameter int BLK_W  = 2,
  parameter int WORD_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel_ld,
  input  logic                    sel_rw,
  input  logic [BLK_W-1:0]        sel_blk,
  input  logic                    word_ld,
  input  logic [WORD_W-1:0]       word_val,
  input  logic                    adv,
  input  logic                    adv_rd,
  output logic [BLK_W+WORD_W-1:0] addr
);
  localparam int ADDR_W = BLK_W + WORD_W;

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] inc_val;
  logic [ADDR_W-1:0] load_val;
  logic              load_any;
  logic              adv_taken;
  logic              idle_cyc;

  eaddr_next #(.BLK_W(BLK_W), .WORD_W(WORD_W), .PAGE_W(PAGE_W)) u_next (
    .cur  (addr_q),
    .mode (adv_mode_e'(adv_rd)),
    .nxt  (inc_val)
  );

  eaddr_load #(.BLK_W(BLK_W), .WORD_W(WORD_W)) u_load (
    .cur      (addr_q),
    .sel_ld   (sel_ld),
    .sel_dir  (sel_dir_e'(sel_rw)),
    .sel_blk  (sel_blk),
    .word_ld  (word_ld),
    .word_val (word_val),
    .merged   (load_val),
    .load_any (load_any)
  );

  // Named events for the checks below
  assign adv_taken = adv && !load_any;
  assign idle_cyc  = !load_any && !adv;

  // Loads take priority over an advance in the same clock (R7)
  always_ff @(posedge clk) begin
    if (!rst_n)         addr_q <= '0;
    else if (load_any)  addr_q <= load_val;
    else if (adv_taken) addr_q <= inc_val;
  end

  assign addr = addr_q;

  assert_full_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_taken && adv_rd) |=> (addr == $past(addr) + ADDR_W'(1)));

  generate
    if (PAGE_W < ADDR_W) begin : g_wr_chk
      assert_page_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_taken && !adv_rd) |=>
          (addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W])) &&
          (addr[PAGE_W-1:0] == $past(addr[PAGE_W-1:0]) + PAGE_W'(1)));
    end
  endgenerate

  assert_word_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    word_ld |=> (addr[WORD_W-1:0] == $past(word_val)));

  assert_rd_sel_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ld && sel_rw && !word_ld && !adv) |=> $stable(addr));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cyc |=> $stable(addr));

  assert_blk_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ld && !sel_rw) |=> (addr[ADDR_W-1:WORD_W] == $past(sel_blk)));

endmodule

// File: tb/tb_eaddr_ctr.sv
module tb_eaddr_ctr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_ld = 1'b0, sel_rw = 1'b0, word_ld = 1'b0, adv = 1'b0, adv_rd = 1'b0;
  logic [1:0] sel_blk = '0;
  logic [7:0] word_val = '0;
  logic [9:0] addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int unsigned expv = 0;

  always #2 clk = ~clk;

  eaddr_ctr dut (
    .clk(clk), .rst_n(rst_n), .sel_ld(sel_ld), .sel_rw(sel_rw), .sel_blk(sel_blk),
    .word_ld(word_ld), .word_val(word_val), .adv(adv), .adv_rd(adv_rd), .addr(addr)
  );

  // Bench model: arithmetic written independently of the RTL
  function automatic int unsigned m_wr(input int unsigned a);
    return (a / 16) * 16 + ((a % 16) + 1) % 16;
  endfunction
  function automatic int unsigned m_rd(input int unsigned a);
    return (a + 1) % 1024;
  endfunction

  task automatic chk(input string tag, input int unsigned e);
    checks++;
    if (addr !== 10'(e)) begin
      errors++;
      $display("FAIL %s: addr=%h expected %h", tag, addr, 10'(e));
    end
  endtask

  // Driven just after a falling edge; one rising edge later the result is sampled at the next falling edge
  task automatic drive(input bit sl, input bit rw, input int blk, input bit wl,
                       input int wv, input bit ad, input bit rd);
    sel_ld = sl; sel_rw = rw; sel_blk = 2'(blk);
    word_ld = wl; word_val = 8'(wv); adv = ad; adv_rd = rd;
    @(negedge clk);
    sel_ld = 0; word_ld = 0; adv = 0;
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", 0);
    expv = 0;
  endtask

  task automatic t_blk_word;
    drive(1, 0, 2, 0, 0, 0, 0);
    expv = 2 * 256;
    chk("R2 block load", expv);
    drive(0, 0, 0, 1, 8'hA7, 0, 0);
    expv = 2 * 256 + 8'hA7;
    chk("R3 word load", expv);
    drive(1, 0, 1, 0, 0, 0, 0);
    expv = 256 + 8'hA7;
    chk("R2 keeps low byte", expv);
  endtask

  task automatic t_write_wrap;
    drive(1, 0, 1, 1, 8'hFE, 0, 0);
    expv = 10'h1FE;
    chk("R3 setup 1FE", expv);
    for (int i = 0; i < 3; i++) begin
      drive(0, 0, 0, 0, 0, 1, 0);
      expv = m_wr(expv);
      chk("R4 write advance", expv);
    end
    if (expv != 10'h1F1) begin
      checks++; errors++;
      $display("FAIL R4: model %h expected 1f1", expv);
    end
  endtask

  task automatic t_read_wrap;
    drive(1, 0, 3, 1, 8'hFF, 0, 0);
    expv = 10'h3FF;
    drive(0, 0, 0, 0, 0, 1, 1);
    expv = m_rd(expv);
    chk("R5 wrap 3FF to 0", expv);
    drive(1, 0, 0, 1, 8'hFF, 0, 0);
    expv = 10'h0FF;
    drive(0, 0, 0, 0, 0, 1, 1);
    expv = m_rd(expv);
    chk("R5 cross block 0FF to 100", expv);
    drive(0, 0, 0, 1, 8'h0F, 0, 0);
    expv = 10'h10F;
    drive(0, 0, 0, 0, 0, 1, 1);
    expv = m_rd(expv);
    chk("R5 cross page 10F to 110", expv);
  endtask

  task automatic t_rd_sel_ignored;
    drive(1, 0, 2, 1, 8'h44, 0, 0);
    expv = 10'h244;
    drive(1, 1, 1, 0, 0, 0, 0);
    chk("R6 read-direction slave address ignored", expv);
    drive(1, 1, 3, 0, 0, 0, 0);
    chk("R6 read-direction slave address ignored again", expv);
  endtask

  task automatic t_collision;
    drive(0, 0, 0, 1, 8'h3C, 1, 1);
    expv = 10'h23C;
    chk("R7 word load beats read advance", expv);
    drive(1, 0, 1, 0, 0, 1, 0);
    expv = 10'h13C;
    chk("R7 block load beats write advance", expv);
    drive(1, 1, 0, 0, 0, 1, 1);
    expv = m_rd(expv);
    chk("R7 read-direction strobe does not block advance", expv);
  endtask

  task automatic t_hold;
    repeat (5) @(negedge clk);
    chk("R8 idle hold", expv);
    sel_blk = 2'd3; word_val = 8'hFF; adv_rd = 1;
    repeat (2) @(negedge clk);
    chk("R8 data without strobes ignored", expv);
  endtask

  task automatic t_dummy_write;
    drive(1, 0, 2, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 8'h35, 0, 0);
    expv = 10'h235;
    drive(1, 1, 0, 0, 0, 0, 0);
    chk("R9 dummy write start", expv);
    for (int i = 0; i < 3; i++) begin
      drive(0, 0, 0, 0, 0, 1, 1);
      expv = m_rd(expv);
      chk("R9 sequential read", expv);
    end
    drive(0, 0, 0, 0, 0, 1, 0);
    expv = m_wr(expv);
    chk("R9 write after read resumes at n+1", expv);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_blk_word();
    t_write_wrap();
    t_read_wrap();
    t_rd_sel_ignored();
    t_collision();
    t_hold();
    t_dummy_write();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule